// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer for one clock domain. Software sees it through a small register port: a mode register, a counter control register and a restart register. A write to the mode register or the counter control register takes effect only when the word carries that register's own access key. A word without the right key changes nothing. The counter control register holds a reload value and a prescaler select. The reload value is counted in units of 2^UNIT_LOG2 prescaled ticks, which is 4096 ticks at the default setting. The prescaler divides the clock by 8, 64, 512 or 4096.

A keyed mode write with the enable bit set loads the down-counter and starts the count. A keyed mode write with the enable bit clear stops the watchdog. While the watchdog runs, software writes the restart key to the restart register to reload the counter. If the counter reaches zero, the block acts once, according to the mode. It either drives a reset pulse that lasts a programmed number of prescaled ticks, or it raises a one-cycle interrupt. It then holds at zero until software restarts or disables it.

The controller has five states: OFF, RUN, RESET_PULSE, IRQ_PULSE and HOLD.

| Transition | Condition |
|---|---|
| any state -> OFF | keyed disable |
| any state -> RUN | keyed enable |
| RUN -> RUN (counter reloaded) | restart key |
| RUN -> RESET_PULSE | counter is zero and the reset action is selected |
| RUN -> IRQ_PULSE | counter is zero and only the interrupt action is selected |
| RUN -> HOLD | counter is zero and neither action is selected |
| RESET_PULSE -> HOLD | pulse length is used up |
| IRQ_PULSE -> HOLD | after one cycle |
| HOLD -> RUN | restart key |

Top module: `keyed_wdog`

## Requirements
- R1: After reset both outputs are low, the watchdog is OFF, and reads at offsets 0x0, 0x4 and 0x8 return zero.
- R2: A write to offset 0x0 is accepted only if bits 23:12 hold 0xABC. Any other key leaves the stored mode unchanged and does not start, stop or reload the counter.
- R3: A write to offset 0x4 is accepted only if bits 25:14 hold 0x920. Any other key leaves the reload value and the prescaler select unchanged.
- R4: Reads use the following layout. Any other offset reads zero.
  - Offset 0x0 returns enable in bit 0, reset-action in bit 1, interrupt-action in bit 2 and the reset-length code in bits 6:4.
  - Offset 0x4 returns the 12-bit reload value in bits 13:2 and the prescaler select in bits 1:0.
  - Key fields and offset 0x8 read as zero.
- R5: A keyed enable write loads the counter with reload × 2^UNIT_LOG2. Each prescaled tick decrements it. The prescaler select codes 0, 1, 2 and 3 divide the clock by 8, 64, 512 and 4096. The timeout output rises reload × 2^UNIT_LOG2 × divisor + 1 clock cycles after the write edge.
- R6: Writing exactly 0x00001999 to offset 0x8 in RUN or HOLD reloads the counter and restarts the prescaler. Any other value has no effect.
- R7: The reset pulse lasts 2, 4, 8 or 16 prescaled ticks for length codes 0, 1, 2 and 3. Codes 4 to 7 give 16 ticks.
- R8: If only the interrupt action is set, the interrupt output is high for exactly one clock cycle. If both actions are set, only the reset pulse is produced.
- R9: After a timeout the counter holds at zero and no further output occurs until a restart key (which returns to RUN) or a keyed enable or disable.
- R10: A keyed mode write with bit 0 clear stops the watchdog. No timeout follows, and an active pulse ends.
- R11: The reset and interrupt outputs are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data including key field |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wd_rst | output | 1 | Timeout reset pulse |
| wd_irq | output | 1 | Timeout interrupt pulse |

## Verification
The embedded assertions check four things on every cycle:
- an unkeyed write never alters the stored mode or counter control fields;
- a keyed disable always lands in OFF, and a restart key in HOLD always reloads the counter;
- the counter stays at zero in HOLD, the interrupt never lasts more than one cycle, and the two outputs never overlap;
- prescaler ticks are never back to back.

Only the bench scenarios can show the end-to-end timing. These cover the exact cycle of the timeout edge for every prescaler divisor, and the reset pulse width for each length code. They also cover that a wrong restart value leaves the deadline unchanged while the right one moves it, and that nothing happens after a disable or while holding.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // register offsets (byte addresses)
    localparam logic [7:0] MODE_OFS = 8'h00;
    localparam logic [7:0] CTRL_OFS = 8'h04;
    localparam logic [7:0] KICK_OFS = 8'h08;

    // access keys
    localparam logic [11:0] MODE_KEY     = 12'hABC;
    localparam int          MODE_KEY_LSB = 12;
    localparam logic [11:0] CTRL_KEY     = 12'h920;
    localparam logic [31:0] KICK_KEY     = 32'h0000_1999;

    // mode field positions
    localparam int MODE_EN_BIT  = 0;
    localparam int MODE_RST_BIT = 1;
    localparam int MODE_IRQ_BIT = 2;
    localparam int MODE_LEN_LSB = 4;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RUN,
        ST_RSTP,
        ST_IRQP,
        ST_HOLD
    } wd_state_e;

    typedef struct packed {
        logic [2:0] rst_len;
        logic       irq_en;
        logic       rst_en;
        logic       en;
    } mode_t;

    // reset pulse length in prescaled ticks: 2,4,8,16, saturating at 16
    function automatic logic [4:0] reset_ticks(input logic [2:0] code);
        logic [4:0] r;
        unique case (code)
            3'd0:    r = 5'd2;
            3'd1:    r = 5'd4;
            3'd2:    r = 5'd8;
            default: r = 5'd16;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int RELOAD_W = 12,
    parameter int SEL_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                rst_en_o,
    output logic                irq_en_o,
    output logic [2:0]          rst_len_o,
    output logic [RELOAD_W-1:0] reload_o,
    output logic [SEL_W-1:0]    sel_o,
    output logic                arm_o,
    output logic                stop_o,
    output logic                kick_o
);

    localparam int RELOAD_LSB = SEL_W;
    localparam int CKEY_LSB   = SEL_W + RELOAD_W;

    mode_t               mode_q;
    logic [RELOAD_W-1:0] reload_q;
    logic [SEL_W-1:0]    sel_q;

    logic hit_mode, hit_ctrl, hit_kick;
    logic mode_ok, ctrl_ok;

    always_comb begin
        hit_mode = bus_wr && (bus_addr == ADDR_W'(MODE_OFS));
        hit_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
        hit_kick = bus_wr && (bus_addr == ADDR_W'(KICK_OFS));
        mode_ok  = hit_mode && (bus_wdata[MODE_KEY_LSB +: 12] == MODE_KEY);
        ctrl_ok  = hit_ctrl && (bus_wdata[CKEY_LSB +: 12] == CTRL_KEY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            reload_q <= '0;
            sel_q    <= '0;
        end else begin
            if (mode_ok) begin
                mode_q.en      <= bus_wdata[MODE_EN_BIT];
                mode_q.rst_en  <= bus_wdata[MODE_RST_BIT];
                mode_q.irq_en  <= bus_wdata[MODE_IRQ_BIT];
                mode_q.rst_len <= bus_wdata[MODE_LEN_LSB +: 3];
            end
            if (ctrl_ok) begin
                reload_q <= bus_wdata[RELOAD_LSB +: RELOAD_W];
                sel_q    <= bus_wdata[SEL_W-1:0];
            end
        end
    end

    // read mux, key fields read as zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(MODE_OFS)) begin
            bus_rdata[MODE_EN_BIT]          = mode_q.en;
            bus_rdata[MODE_RST_BIT]         = mode_q.rst_en;
            bus_rdata[MODE_IRQ_BIT]         = mode_q.irq_en;
            bus_rdata[MODE_LEN_LSB +: 3]    = mode_q.rst_len;
        end else if (bus_addr == ADDR_W'(CTRL_OFS)) begin
            bus_rdata[RELOAD_LSB +: RELOAD_W] = reload_q;
            bus_rdata[SEL_W-1:0]              = sel_q;
        end
    end

    always_comb begin
        rst_en_o  = mode_q.rst_en;
        irq_en_o  = mode_q.irq_en;
        rst_len_o = mode_q.rst_len;
        reload_o  = reload_q;
        sel_o     = sel_q;
        arm_o     = mode_ok && bus_wdata[MODE_EN_BIT];
        stop_o    = mode_ok && !bus_wdata[MODE_EN_BIT];
        kick_o    = hit_kick && (bus_wdata == KICK_KEY);
    end

    // R2
    mode_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_mode && bus_wdata[MODE_KEY_LSB +: 12] != MODE_KEY) |=> $stable(mode_q));

    // R3
    ctrl_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ctrl && bus_wdata[CKEY_LSB +: 12] != CTRL_KEY)
            |=> ($stable(reload_q) && $stable(sel_q)));

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int SEL_W    = 2,
    parameter int PRE_STEP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    localparam int NSEL = 2 ** SEL_W;
    localparam int PC_W = PRE_STEP * NSEL;

    logic [PC_W-1:0] lim [NSEL];
    logic [PC_W-1:0] pcnt_q;

    // terminal counts 2^(PRE_STEP*(g+1)) - 1
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign lim[g] = {PC_W{1'b1}} >> (PC_W - PRE_STEP * (g + 1));
    end

    assign tick_o = run_i && !clr_i && (pcnt_q >= lim[sel_i]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clr_i || !run_i || tick_o) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int RELOAD_W  = 12,
    parameter int UNIT_LOG2 = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm_i,
    input  logic                stop_i,
    input  logic                kick_i,
    input  logic                tick_i,
    input  logic                rst_en_i,
    input  logic                irq_en_i,
    input  logic [2:0]          rst_len_i,
    input  logic [RELOAD_W-1:0] reload_i,
    output logic                run_o,
    output logic                clr_o,
    output logic                rst_o,
    output logic                irq_o
);

    localparam int CNT_W = RELOAD_W + UNIT_LOG2;

    wd_state_e        st, nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [4:0]       plen_q;
    logic             load;

    assign load = !stop_i && (arm_i || (kick_i && (st == ST_RUN || st == ST_HOLD)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        if (stop_i) begin
            nxt = ST_OFF;
        end else if (arm_i) begin
            nxt = ST_RUN;
        end else begin
            unique case (st)
                ST_OFF:  nxt = ST_OFF;
                ST_RUN: begin
                    if (kick_i)           nxt = ST_RUN;
                    else if (cnt_q == '0) nxt = rst_en_i ? ST_RSTP :
                                                (irq_en_i ? ST_IRQP : ST_HOLD);
                end
                ST_RSTP: if (tick_i && plen_q == 5'd1) nxt = ST_HOLD;
                ST_IRQP: nxt = ST_HOLD;
                ST_HOLD: if (kick_i) nxt = ST_RUN;
                default: nxt = ST_OFF;
            endcase
        end
    end

    // counter and pulse-length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            plen_q <= '0;
        end else begin
            if (stop_i)
                cnt_q <= '0;
            else if (load)
                cnt_q <= {reload_i, {UNIT_LOG2{1'b0}}};
            else if (st == ST_RUN && tick_i && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;

            if (nxt == ST_RSTP && st != ST_RSTP)
                plen_q <= reset_ticks(rst_len_i);
            else if (st == ST_RSTP && tick_i && plen_q != '0)
                plen_q <= plen_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        rst_o = 1'b0;
        irq_o = 1'b0;
        run_o = 1'b0;
        unique case (st)
            ST_RUN:  run_o = 1'b1;
            ST_RSTP: begin run_o = 1'b1; rst_o = 1'b1; end
            ST_IRQP: irq_o = 1'b1;
            default: ;
        endcase
        clr_o = load || (nxt == ST_RSTP && st != ST_RSTP);
    end

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R10
    stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (st == ST_OFF && !rst_o && !irq_o));

    // R9
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> (cnt_q == '0));

    // R6
    kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_i && st == ST_HOLD && !stop_i && !arm_i)
            |=> (st == ST_RUN && cnt_q == {reload_i, {UNIT_LOG2{1'b0}}}));

    // R11
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_o && irq_o));

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
    parameter int ADDR_W    = 4,
    parameter int RELOAD_W  = 12,
    parameter int SEL_W     = 2,
    parameter int PRE_STEP  = 3,
    parameter int UNIT_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wd_rst,
    output logic              wd_irq
);

    logic                rst_en, irq_en;
    logic [2:0]          rst_len;
    logic [RELOAD_W-1:0] reload;
    logic [SEL_W-1:0]    sel;
    logic                arm, stop, kick;
    logic                run, clr, tick;

    wdog_regs #(
        .ADDR_W   (ADDR_W),
        .RELOAD_W (RELOAD_W),
        .SEL_W    (SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_en_o  (rst_en),
        .irq_en_o  (irq_en),
        .rst_len_o (rst_len),
        .reload_o  (reload),
        .sel_o     (sel),
        .arm_o     (arm),
        .stop_o    (stop),
        .kick_o    (kick)
    );

    wdog_prescaler #(
        .SEL_W    (SEL_W),
        .PRE_STEP (PRE_STEP)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .clr_i  (clr),
        .sel_i  (sel),
        .tick_o (tick)
    );

    wdog_fsm #(
        .RELOAD_W  (RELOAD_W),
        .UNIT_LOG2 (UNIT_LOG2)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm),
        .stop_i    (stop),
        .kick_i    (kick),
        .tick_i    (tick),
        .rst_en_i  (rst_en),
        .irq_en_i  (irq_en),
        .rst_len_i (rst_len),
        .reload_i  (reload),
        .run_o     (run),
        .clr_o     (clr),
        .rst_o     (wd_rst),
        .irq_o     (wd_irq)
    );

endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;

    localparam int UNIT_LOG2 = 3;   // 8 ticks per reload unit keeps runs short
    localparam int UNIT      = 1 << UNIT_LOG2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_rst, wd_irq;

    keyed_wdog #(.UNIT_LOG2(UNIT_LOG2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wd_rst    (wd_rst),
        .wd_irq    (wd_irq)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct { bit is_rst; int start; int len; string req; } exp_t;
    exp_t q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    bit   in_pulse = 0, p_rst = 0, have = 0;
    int   p_len = 0;
    exp_t cur;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!in_pulse && (wd_rst || wd_irq)) begin
                in_pulse = 1; p_rst = wd_rst; p_len = 1;
                if (q.size() == 0) begin
                    check(0, "R9 unexpected timeout output", cyc, 0);
                    have = 0;
                end else begin
                    cur  = q.pop_front();
                    have = 1;
                    check(p_rst == cur.is_rst, {cur.req, " output kind"}, p_rst, cur.is_rst);
                    check(cyc == cur.start, {cur.req, " timeout cycle"}, cyc, cur.start);
                end
            end else if (in_pulse && (p_rst ? wd_rst : wd_irq)) begin
                p_len++;
            end else if (in_pulse) begin
                in_pulse = 0;
                if (have) check(p_len == cur.len, {cur.req, " pulse length"}, p_len, cur.len);
                have = 0;
            end
        end
    end

    // ---------------- driver ----------------
    function automatic logic [31:0] mode_w(bit en, bit rs, bit iq, int len, logic [11:0] key);
        return ({20'd0, key} << 12) | (32'(len) << 4) | (32'(iq) << 2) | (32'(rs) << 1) | 32'(en);
    endfunction

    function automatic logic [31:0] ctrl_w(int reload, int sel, logic [11:0] key);
        return ({20'd0, key} << 14) | (32'(reload) << 2) | 32'(sel);
    endfunction

    // returns the cycle number of the write edge
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d, output int w);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        w = cyc;
    endtask

    task automatic read_chk(input logic [3:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata == e, req, bus_rdata, e);
    endtask

    task automatic expect_out(input bit is_rst, input int start, input int len, input string req);
        exp_t x;
        x.is_rst = is_rst; x.start = start; x.len = len; x.req = req;
        q.push_back(x);
    endtask

    task automatic wait_idle();
        wait (q.size() == 0 && !in_pulse);
        repeat (3) @(negedge clk);
    endtask

    function automatic int div_of(int sel);
        return 1 << (3 * (sel + 1));
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        int w;
        int t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(!wd_rst && !wd_irq, "R1 outputs low after reset", {wd_rst, wd_irq}, 0);
        read_chk(4'h0, 32'h0, "R1 mode reads zero");
        read_chk(4'h4, 32'h0, "R1 ctrl reads zero");
        read_chk(4'h8, 32'h0, "R1 restart reads zero");

        // R2 bad mode key ignored; R4 readback
        bus_write(4'h0, mode_w(0, 1, 0, 3, 12'hABD), w);
        read_chk(4'h0, 32'h0, "R2 mode write with wrong key ignored");
        bus_write(4'h0, mode_w(0, 1, 0, 3, 12'hABC), w);
        read_chk(4'h0, 32'h32, "R4 mode readback layout");

        // R3 bad ctrl key ignored; R4 readback
        bus_write(4'h4, ctrl_w(2, 1, 12'h921), w);
        read_chk(4'h4, 32'h0, "R3 ctrl write with wrong key ignored");
        bus_write(4'h4, ctrl_w(2, 0, 12'h920), w);
        read_chk(4'h4, 32'h8, "R4 ctrl readback layout");
        read_chk(4'h8, 32'h0, "R4 restart reads zero");

        // R5 R7 timeout with reset pulse, code 1 -> 4 ticks
        bus_write(4'h0, mode_w(1, 1, 0, 1, 12'hABC), w);
        expect_out(1, w + 2*UNIT*8 + 1, 4*8, "R5 R7 reset timeout");
        wait_idle();

        // R9 hold: nothing more happens
        repeat (400) @(negedge clk);
        check(!wd_rst && !wd_irq && q.size() == 0, "R9 hold after timeout", {wd_rst, wd_irq}, 0);

        // R9 R6 restart from hold
        bus_write(4'h8, 32'h0000_1999, w);
        expect_out(1, w + 2*UNIT*8 + 1, 32, "R9 R6 restart from hold");
        wait_idle();

        // R6 wrong restart value ignored, right one moves the deadline
        bus_write(4'h0, mode_w(1, 1, 0, 1, 12'hABC), w);
        repeat (40) @(negedge clk);
        bus_write(4'h8, 32'h0000_1998, t2);
        repeat (30) @(negedge clk);
        bus_write(4'h8, 32'h0000_1999, t2);
        expect_out(1, t2 + 2*UNIT*8 + 1, 32, "R6 restart reloads counter");
        wait_idle();

        // R2 unkeyed disable does not stop the count
        bus_write(4'h0, mode_w(1, 1, 0, 1, 12'hABC), w);
        expect_out(1, w + 2*UNIT*8 + 1, 32, "R2 unkeyed disable ignored");
        repeat (30) @(negedge clk);
        bus_write(4'h0, mode_w(0, 1, 0, 1, 12'h123), t2);
        wait_idle();

        // R10 keyed disable stops
        bus_write(4'h0, mode_w(1, 1, 0, 1, 12'hABC), w);
        repeat (50) @(negedge clk);
        bus_write(4'h0, mode_w(0, 1, 0, 1, 12'hABC), w);
        repeat (400) @(negedge clk);
        check(!wd_rst && !wd_irq && q.size() == 0, "R10 no timeout after disable", {wd_rst, wd_irq}, 0);

        // R10 disable during an active reset pulse ends it
        bus_write(4'h0, mode_w(1, 1, 0, 3, 12'hABC), w);
        expect_out(1, w + 2*UNIT*8 + 1, 40, "R10 disable ends pulse");
        repeat (2*UNIT*8 + 1 + 38) @(negedge clk);
        bus_write(4'h0, mode_w(0, 1, 0, 3, 12'hABC), t2);
        wait_idle();
        check(!wd_rst, "R10 pulse ended by disable", wd_rst, 0);

        // R8 R5 interrupt, divide by 64
        bus_write(4'h4, ctrl_w(1, 1, 12'h920), w);
        bus_write(4'h0, mode_w(1, 0, 1, 0, 12'hABC), w);
        expect_out(0, w + UNIT*div_of(1) + 1, 1, "R8 R5 irq one cycle div64");
        wait_idle();

        // R7 R8 both actions set, code 5 saturates to 16 ticks
        bus_write(4'h4, ctrl_w(2, 0, 12'h920), w);
        bus_write(4'h0, mode_w(1, 1, 1, 5, 12'hABC), w);
        expect_out(1, w + 2*UNIT*8 + 1, 16*8, "R7 R8 reset wins, code 5");
        wait_idle();

        // R7 code 0, R5 reload 0
        bus_write(4'h4, ctrl_w(0, 0, 12'h920), w);
        bus_write(4'h0, mode_w(1, 1, 0, 0, 12'hABC), w);
        expect_out(1, w + 1, 2*8, "R7 R5 code 0 reload 0");
        wait_idle();

        // R5 divide by 512 and 4096
        bus_write(4'h4, ctrl_w(1, 2, 12'h920), w);
        bus_write(4'h0, mode_w(1, 0, 1, 0, 12'hABC), w);
        expect_out(0, w + UNIT*div_of(2) + 1, 1, "R5 div512");
        wait_idle();
        bus_write(4'h4, ctrl_w(1, 3, 12'h920), w);
        bus_write(4'h0, mode_w(1, 0, 1, 0, 12'hABC), w);
        expect_out(0, w + UNIT*div_of(3) + 1, 1, "R5 div4096");
        wait_idle();

        // R11 final idle state
        repeat (20) @(negedge clk);
        check(!(wd_rst && wd_irq) && q.size() == 0, "R11 outputs exclusive, queue drained",
              q.size(), 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule